// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Adder

This block adds two unsigned binary operands of a parameterised width in a single combinational pass. It has no clock and no state. Each bit position first classifies itself: it either creates a carry (both operand bits set) or passes an incoming carry through (exactly one operand bit set). These per-bit pairs are then folded together by an associative merge operator. A group "creates" a carry when its upper part creates one, or when the lower part creates one and the upper part passes it through. A group "passes" a carry only when both parts pass it.

The merge network is built recursively. The bit range is cut into a lower and an upper half. Each half is solved on its own, and the final group result of the lower half is then merged into every position of the upper half. This gives the group result for every span that starts at bit 0 after about log2(W) merge levels. Because there is no carry input, the "creates" flag of span 0..i is exactly the carry leaving bit i. The sum bits and the carry out follow from these carries with one XOR level.

The width is a parameter with a default of 16. A power of two gives a balanced tree. Other widths are also built correctly, with an uneven split.

Top module: `ppa_adder`

## Requirements
- R1: `sum_o[0]` equals `a_i[0] XOR b_i[0]` for every operand pair.
- R2: `{cout_o, sum_o}` equals the (W+1)-bit arithmetic sum `a_i + b_i` for all operand pairs, with `cout_o` as bit W.
- R3: `cout_o` is 1 whenever `a_i[W-1]` and `b_i[W-1]` are both 1, and 0 whenever both are 0.
- R4: A carry created at a low bit travels through every higher bit that passes it. All-ones plus one gives `sum_o` = 0 and `cout_o` = 1.
- R5: The carry into bit 0 is zero. Adding zero to any operand returns that operand with `cout_o` = 0, and zero plus zero gives all-zero outputs.
- R6: When operands have no common set bit (`a_i & b_i` = 0), no carry appears. `sum_o` equals `a_i | b_i` and `cout_o` = 0; for example `b_i = ~a_i` gives all ones.
- R7: The outputs are a pure function of the present operands. They settle after an operand change with no clock edge involved.
- R8: The same source computes correct results at a width other than the default. This is checked exhaustively at W = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, unsigned |
| b_i | input | W | Second operand, unsigned |
| sum_o | output | W | Low W bits of the sum |
| cout_o | output | 1 | Carry leaving the most significant bit |

## Verification
Every result of this block is due in the same cycle as its operands, with zero register stages between input and output. The bench therefore drives new operands just after a rising edge of its own clock and samples sum and carry at the following falling edge. That sample point lies half a period after the drive and before any further edge. Some checks change the operands a second time between two edges and sample again before the next edge. This shows that the outputs follow the operands without a clock (R7).

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    // Carry behaviour of one bit or of a contiguous span of bits.
    typedef struct packed {
        logic mk;   // span creates a carry by itself
        logic pt;   // span passes an incoming carry through
    } span_t;

    // Merge a lower span with the span directly above it.
    function automatic span_t span_merge(input span_t lower, input span_t upper);
        span_t r;
        r.mk = upper.mk | (lower.mk & upper.pt);
        r.pt = upper.pt & lower.pt;
        return r;
    endfunction

endpackage

// File: rtl/ppa_merge_cell.sv
module ppa_merge_cell
    import ppa_pkg::*;
(
    input  span_t lower_i,
    input  span_t upper_i,
    output span_t joint_o
);

    always_comb begin
        joint_o = span_merge(lower_i, upper_i);
    end

    // A span cannot both create and pass a carry when its parts cannot.
    always_comb begin
        if (!(lower_i.mk && lower_i.pt) && !(upper_i.mk && upper_i.pt)) begin
            AST_SPAN_EXCLUSIVE: assert (!(joint_o.mk && joint_o.pt)); // R6
        end
    end

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree
    import ppa_pkg::*;
#(
    parameter int W = 16
) (
    input  span_t [W-1:0] leaf_i,
    output span_t [W-1:0] pref_o
);

    generate
        if (W == 1) begin : g_leaf
            assign pref_o = leaf_i;
        end else begin : g_split
            localparam int LO = W / 2;
            localparam int HI = W - LO;

            span_t [LO-1:0] lo_pref;
            span_t [HI-1:0] hi_pref;
            span_t [HI-1:0] mixed;

            ppa_prefix_tree #(.W(LO)) u_lower (
                .leaf_i (leaf_i[LO-1:0]),
                .pref_o (lo_pref)
            );

            ppa_prefix_tree #(.W(HI)) u_upper (
                .leaf_i (leaf_i[W-1:LO]),
                .pref_o (hi_pref)
            );

            // Fan the lower half's full-span result into every upper position.
            for (genvar j = 0; j < HI; j++) begin : g_fan
                ppa_merge_cell u_mix (
                    .lower_i (lo_pref[LO-1]),
                    .upper_i (hi_pref[j]),
                    .joint_o (mixed[j])
                );
            end

            assign pref_o = {mixed, lo_pref};
        end
    endgenerate

    // Cross-check the tree against a serial walk over the leaves.
    always_comb begin
        logic run_pt;
        logic run_mk;
        run_pt = 1'b1;
        run_mk = 1'b0;
        for (int k = 0; k < W; k++) begin
            run_mk = leaf_i[k].mk | (leaf_i[k].pt & run_mk);
            run_pt = run_pt & leaf_i[k].pt;
            AST_PREFIX_PASS: assert (pref_o[k].pt == run_pt);  // R6
            AST_PREFIX_MAKE: assert (pref_o[k].mk == run_mk);  // R4
        end
    end

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
    import ppa_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int TOP = W - 1;

    typedef struct packed {
        logic [W-1:0] sum;
        logic         cout;
    } result_t;

    span_t [W-1:0] leaf;
    span_t [W-1:0] pref;
    result_t       res_d;

    // Per-bit classification.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            leaf[i].mk = a_i[i] & b_i[i];
            leaf[i].pt = a_i[i] ^ b_i[i];
        end
    end

    ppa_prefix_tree #(.W(W)) u_tree (
        .leaf_i (leaf),
        .pref_o (pref)
    );

    // Carry out of bit i is the create flag of span 0..i (no carry in).
    always_comb begin
        res_d.sum[0] = leaf[0].pt;
        for (int i = 1; i < W; i++) begin
            res_d.sum[i] = leaf[i].pt ^ pref[i-1].mk;
        end
        res_d.cout = pref[TOP].mk;
    end

    assign sum_o  = res_d.sum;
    assign cout_o = res_d.cout;

    always_comb begin
        AST_SUM_ARITH: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i})); // R2
        AST_LSB_XOR:   assert (sum_o[0] == (a_i[0] ^ b_i[0]));                  // R1
        if (a_i[TOP] && b_i[TOP]) begin
            AST_COUT_MAKE: assert (cout_o);                                     // R3
        end
        if (!a_i[TOP] && !b_i[TOP]) begin
            AST_COUT_KILL: assert (!cout_o);                                    // R3
        end
        if (b_i == '0) begin
            AST_ZERO_ADD: assert (sum_o == a_i && !cout_o);                     // R5
        end
    end

endmodule

// File: tb/tb_ppa_adder.sv
module tb_ppa_adder;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 16;
    localparam int NVEC       = 8;
    localparam int NRAND      = 2000;

    localparam logic [NW-1:0] VEC_A [NVEC] = '{
        16'h0000, 16'hFFFF, 16'h8000, 16'hAAAA,
        16'h1234, 16'hFFFF, 16'h7FFF, 16'h00FF};
    localparam logic [NW-1:0] VEC_B [NVEC] = '{
        16'h0000, 16'h0001, 16'h8000, 16'h5555,
        16'h4321, 16'hFFFF, 16'h0001, 16'h0F01};
    localparam logic [NW:0] VEC_X [NVEC] = '{
        17'h00000, 17'h10000, 17'h10000, 17'h0FFFF,
        17'h05555, 17'h1FFFE, 17'h08000, 17'h01000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0] a, b, sum;
    logic          cout;
    logic [3:0]    a4, b4, sum4;
    logic          cout4;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppa_adder #(.W(NW)) dut (
        .a_i (a), .b_i (b), .sum_o (sum), .cout_o (cout)
    );

    ppa_adder #(.W(4)) dut_w4 (
        .a_i (a4), .b_i (b4), .sum_o (sum4), .cout_o (cout4)
    );

    task automatic check(input string req, input logic [NW:0] act, input logic [NW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply(input logic [NW-1:0] x, input logic [NW-1:0] y);
        @(posedge clk);
        a = x;
        b = y;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        a = '0; b = '0; a4 = '0; b4 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 reset state", {cout, sum}, 17'h0);
        rst = 1'b0;

        // Table walk: R2 plus corner cases of R3, R4, R5, R6
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC_A[v], VEC_B[v]);
            check("R2 table", {cout, sum}, VEC_X[v]);
        end

        // R4: all ones plus one
        apply(16'hFFFF, 16'h0001);
        check("R4 ripple through all bits", {cout, sum}, 17'h10000);
        // R4: carry from bit 3 through bits 4..11
        apply(16'h0FF8, 16'h0008);
        check("R4 partial chain", {cout, sum}, 17'h01000);

        // R5: zero operand
        apply(16'hBEEF, 16'h0000);
        check("R5 add zero", {cout, sum}, 17'h0BEEF);

        // R6: disjoint operands
        apply(16'hC3A5, 16'h3C5A);
        check("R6 complement", {cout, sum}, 17'h0FFFF);
        apply(16'h0F00, 16'h00F0);
        check("R6 disjoint", {cout, sum}, 17'h00FF0);

        // R3: both top bits set / clear
        apply(16'h8001, 16'h8000);
        check("R3 cout made", {8'h0, cout}, 17'h1);
        apply(16'h7FFF, 16'h7FFF);
        check("R3 cout killed", {8'h0, cout}, 17'h0);

        // R1: LSB
        apply(16'h0001, 16'h0000);
        check("R1 lsb", {16'h0, sum[0]}, 17'h1);
        apply(16'h0001, 16'h0001);
        check("R1 lsb both set", {16'h0, sum[0]}, 17'h0);

        // R7: operands change twice between edges, outputs follow each
        @(posedge clk);
        a = 16'h1111; b = 16'h2222;
        #1;
        check("R7 first change", {cout, sum}, 17'h03333);
        a = 16'hF000; b = 16'h1000;
        #1;
        check("R7 second change", {cout, sum}, 17'h10000);

        // R2: random vectors
        for (int r = 0; r < NRAND; r++) begin
            logic [NW-1:0] x, y;
            x = NW'($urandom);
            y = NW'($urandom);
            apply(x, y);
            check("R2 random", {cout, sum}, {1'b0, x} + {1'b0, y});
        end

        // R8: exhaustive at width 4
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(posedge clk);
                a4 = 4'(i);
                b4 = 4'(j);
                @(negedge clk);
                check("R8 width 4", {12'h0, cout4, sum4}, 17'(i + j));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule